// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the reset line for a processor from three causes: the chip's own power-on, a supply monitor that reports the rail as low, and a watchdog that has not been restarted in time. The supply monitor's verdict arrives as an asynchronous power-good level. It is brought into the clock domain through two flops before any logic uses it. Whenever a cause fires, reset is asserted. It is then held for a fixed number of timebase ticks so that the supply and the oscillator can settle.

A single prescaler derives one tick from the clock. That tick paces both the hold interval and the watchdog interval. A static two-bit input picks the watchdog period: a long, a medium or a short timeout, or off. Software restarts the watchdog with a one-cycle strobe. The output polarity is fixed at build time by a parameter.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_rst` is asserted. When `rst_n` rises with `pwr_good` high, reset releases exactly 2 + PRESCALE*HOLD_TICKS clock edges after the rising edge of `rst_n`.
- R2: When `pwr_good` goes low, reset is asserted on the third clock edge after the change. It stays asserted for as long as `pwr_good` stays low.
- R3: When `pwr_good` returns high, reset releases exactly 2 + PRESCALE*HOLD_TICKS clock edges later.
- R4: Take the last clock edge at which a restart strobe was accepted, or at which reset released. If no strobe is accepted for PRESCALE*T clock edges after that edge, reset is asserted on that edge. T is the selected timeout in ticks.
- R5: `wd_sel` encodes the timeout. 2'b00 is WD_LONG_TICKS, 2'b01 is WD_MED_TICKS and 2'b10 is WD_SHORT_TICKS. 2'b11 turns the watchdog off, so it never asserts reset and its counter stays cleared.
- R6: An accepted strobe clears the watchdog count and restarts the timebase. Strobes spaced closer than the timeout keep reset deasserted.
- R7: Strobes that arrive while reset is asserted have no effect: they neither shorten nor extend the hold. The watchdog counts from zero when reset releases.
- R8: A watchdog timeout holds reset for exactly PRESCALE*HOLD_TICKS clock edges.
- R9: With RST_ACTIVE_LOW = 0, `cpu_rst` is high while reset is asserted. With RST_ACTIVE_LOW = 1, it is low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| pwr_good | input | 1 | Asynchronous supply-good level from the comparator |
| wd_kick | input | 1 | Watchdog restart strobe |
| wd_sel | input | 2 | Watchdog timeout select (static) |
| cpu_rst | output | 1 | Processor reset, polarity set by RST_ACTIVE_LOW |

## Verification
Some properties are checked on every cycle:
- a low synchronised supply flag or a watchdog expiry forces reset on the next cycle;
- reset releases only on a timebase tick;
- the off setting, an accepted strobe, or being in reset leaves the watchdog count at zero.

Other properties only the bench scenarios can show:
- the exact end-to-end durations (power-on hold, supply-dip recovery, each timeout and the watchdog hold);
- that strobes during reset do not change the hold;
- that the two polarity builds are complements of each other.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MED   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/supv_timebase.sv
module supv_timebase #(
  parameter int PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the prescaler never leaves its range, so ticks stay evenly spaced
  assert_prescale_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: a restart puts the phase back to zero
  assert_restart_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_ok,
  input  logic wd_expire,
  input  logic tick,
  output logic in_reset,
  output logic hold_restart
);
  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic          active_q, active_d;
  logic [HW-1:0] cnt_q, cnt_d;

  assign hold_restart = !pg_ok || wd_expire;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (hold_restart) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && tick) begin
      if (cnt_q == HOLD_LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign in_reset = active_q;

  assert_low_supply_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok |=> in_reset);
  assert_expiry_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> in_reset);
  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> $past(tick));
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MED_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_reset,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       kick_ok,
  output logic       expire
);
  localparam int WW = $clog2(WD_LONG_TICKS + 1);

  wd_sel_e       mode;
  logic [WW-1:0] limit;
  logic [WW-1:0] cnt_q, cnt_d;
  logic          enabled;

  assign mode = wd_sel_e'(sel);

  always_comb begin
    case (mode)
      WD_LONG:  limit = WW'(WD_LONG_TICKS - 1);
      WD_MED:   limit = WW'(WD_MED_TICKS - 1);
      WD_SHORT: limit = WW'(WD_SHORT_TICKS - 1);
      default:  limit = '0;
    endcase
  end

  assign enabled = !in_reset && (mode != WD_OFF);
  assign kick_ok = kick && !in_reset;
  assign expire  = enabled && !kick_ok && tick && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!enabled || kick_ok) cnt_d = '0;
    else if (expire)         cnt_d = '0;
    else if (tick)           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_off_holds_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WD_OFF) |=> (cnt_q == '0));
  assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (cnt_q == '0));
  assert_idle_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> (cnt_q == '0));
  assert_expire_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (tick && !in_reset));
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int PRESCALE       = 1000,
  parameter int HOLD_TICKS     = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MED_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200,
  parameter bit RST_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       cpu_rst
);
  logic pg_ok, tick, in_reset, hold_restart, kick_ok, wd_expire;

  supv_sync2 u_pg_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pwr_good),
    .q_sync (pg_ok)
  );

  supv_timebase #(.PRESCALE(PRESCALE)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(hold_restart || kick_ok),
    .tick   (tick)
  );

  supv_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_ok       (pg_ok),
    .wd_expire   (wd_expire),
    .tick        (tick),
    .in_reset    (in_reset),
    .hold_restart(hold_restart)
  );

  supv_wdog #(
    .WD_LONG_TICKS (WD_LONG_TICKS),
    .WD_MED_TICKS  (WD_MED_TICKS),
    .WD_SHORT_TICKS(WD_SHORT_TICKS)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .in_reset(in_reset),
    .kick    (wd_kick),
    .sel     (wd_sel),
    .kick_ok (kick_ok),
    .expire  (wd_expire)
  );

  generate
    if (RST_ACTIVE_LOW) begin : g_active_low
      assign cpu_rst = ~in_reset;
    end else begin : g_active_high
      assign cpu_rst = in_reset;
    end
  endgenerate

  // R7: a strobe during reset never restarts the timebase
  assert_kick_ignored_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && wd_kick) |-> !kick_ok);
endmodule

// File: tb/test_supv_reset_ctrl.sv
`timescale 1ns/1ps
module test_supv_reset_ctrl;
  localparam int P  = 4;
  localparam int H  = 8;
  localparam int TL = 28;
  localparam int TM = 12;
  localparam int TS = 4;
  localparam int WIN = 3 * TL * P;

  localparam logic [1:0] SEL_V [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         EXP_V [4] = '{TL * P, TM * P, TS * P, WIN};

  logic clk = 1'b0;
  logic rst_n, pg, kick;
  logic [1:0] sel;
  logic rst_hi, rst_lo;
  int checks = 0;
  int errors = 0;
  int pol_err = 0;

  always #2.5 clk = ~clk;

  supv_reset_ctrl #(.PRESCALE(P), .HOLD_TICKS(H), .WD_LONG_TICKS(TL),
    .WD_MED_TICKS(TM), .WD_SHORT_TICKS(TS), .RST_ACTIVE_LOW(1'b0)) i_supv_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg), .wd_kick(kick), .wd_sel(sel), .cpu_rst(rst_hi));

  supv_reset_ctrl #(.PRESCALE(P), .HOLD_TICKS(H), .WD_LONG_TICKS(TL),
    .WD_MED_TICKS(TM), .WD_SHORT_TICKS(TS), .RST_ACTIVE_LOW(1'b1)) i_supv_reset_ctrl_n (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg), .wd_kick(kick), .wd_sel(sel), .cpu_rst(rst_lo));

  // R9 monitor: the two builds must be complements at every sample
  always @(negedge clk) if (rst_lo !== ~rst_hi) pol_err++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic want, input int limit, output int n);
    n = 0;
    while (rst_hi !== want && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_kick;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, m, bad;
    rst_n = 1'b0; pg = 1'b1; kick = 1'b0; sel = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 reset state high", int'(rst_hi), 1);
    chk("R9 reset state low", int'(rst_lo), 0);

    // R1: power-on hold
    rst_n = 1'b1;
    count_until(1'b0, 1000, n);
    chk("R1 power-on hold", n, 2 + P * H);

    // R5: off setting never times out
    count_until(1'b1, WIN, n);
    chk("R5 off no timeout", n, WIN);

    // R2 / R3: supply dip
    @(negedge clk) pg = 1'b0;
    count_until(1'b1, 50, n);
    chk("R2 low supply latency", n, 3);
    repeat (20) @(negedge clk);
    chk("R2 held while low", int'(rst_hi), 1);
    pg = 1'b1;
    count_until(1'b0, 1000, n);
    chk("R3 recovery hold", n, 2 + P * H);

    // Vector table: each timeout select measured from a fresh release
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sel = SEL_V[i];
      pg  = 1'b0;
      repeat (5) @(negedge clk);
      pg = 1'b1;
      count_until(1'b0, 1000, n);
      count_until(1'b1, WIN, n);
      chk($sformatf("R5 timeout sel=%0d", SEL_V[i]), n, EXP_V[i]);
      if (SEL_V[i] != 2'b11) begin
        count_until(1'b0, 1000, m);
        chk($sformatf("R8 watchdog hold sel=%0d", SEL_V[i]), m, P * H);
      end
    end

    // R6: regular strobes keep reset away
    sel = 2'b10;
    pulse_kick();
    bad = 0;
    for (int j = 0; j < 10; j++) begin
      repeat (9) begin
        @(negedge clk);
        if (rst_hi) bad++;
      end
      pulse_kick();
    end
    chk("R6 strobes keep reset low", bad, 0);

    // R4: timeout measured from the last accepted strobe
    count_until(1'b1, 1000, n);
    chk("R4 timeout after strobe", n, TS * P);

    // R7: strobes held during the hold do not change it
    kick = 1'b1;
    count_until(1'b0, 1000, m);
    kick = 1'b0;
    chk("R7 hold unaffected by strobes", m, P * H);
    count_until(1'b1, 1000, n);
    chk("R7 count from zero after release", n, TS * P);

    chk("R9 polarity complement", pol_err, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule